// File: doc/BRIEF.md
# Privileged System Control Register

This block holds a single 32-bit system configuration word inside a coprocessor-style register file. Software reaches it through a simple command port made of a write strobe, a read strobe and a data bus. The port is honoured only while the privileged-mode input is high. The word holds the switches for:

- address translation, strict alignment checking, unaligned access and branch prediction;
- the instruction cache and the vector placement;
- the endian value used on exception entry;
- fast-interrupt masking, legacy PC-load behaviour and the extended page-table format.

Each switch drives its own output pin to the rest of the core. The block also supplies two derived values: the exception vector base address, and the endian bit that the status register takes on exception entry.

The reset value depends on two strap inputs. One strap sets the vector placement. A 2-bit endian strap sets the unaligned-access bit and the exception-endian bit. Some bit positions are constants that ignore writes. A write changes the register on the clock edge that samples the strobe. An unprivileged access is refused and raises a one-cycle error pulse.

Top module: `sys_ctrl_reg`

## Requirements
- R1: When `wr_en_i` and `priv_i` are both high, the writable bits take `wdata_i` on that rising edge. A read made in the same cycle returns the value held before the write.
- R2: A write with `priv_i` low leaves the register unchanged. Any access with `priv_i` low (`wr_en_i` or `rd_en_i` high) sets `undef_o` for exactly the following cycle.
- R3: `rdata_o` shows the register view only when `rd_en_i` and `priv_i` are both high. At all other times it is zero.
- R4: While `rst_ni` is low, every writable bit clears except bits 13, 22 and 25. Bit 13 (vector high) takes the level of `strap_vec_hi_i`.
- R5: On reset, the endian strap sets bit 22 (unaligned) and bit 25 (exception endian): 00 gives 0/0, 10 gives 1/0, 11 gives 1/1. The reserved code 01 behaves as 00 and sets `strap_err_o`. That flag holds until the next reset. Strap changes after reset have no effect.
- R6: Bits 21:16 always read 6'b000101 and bit 14 always reads 1, whatever is written.
- R7: Bits 24, 26 and every other bit not listed in R6 or R8 always read 0, whatever is written.
- R8: Writable bits and their outputs are: bit 0 `mmu_en_o`, bit 1 `align_chk_o`, bit 11 `pred_en_o`, bit 12 `icache_en_o`, bit 13 `vec_hi_o`, bit 15 `l4_o`, bit 22 `unalign_en_o`, bit 23 `xp_o`, bit 25 `exc_endian_o`, bit 27 `nmfi_o`.
- R9: `vec_base_o` is 32'h00000000 when bit 13 is 0 and 32'hFFFF0000 when it is 1.
- R10: `exc_endian_o`, the endian bit loaded into the status register on exception entry, equals bit 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_vec_hi_i | input | 1 | Reset value for vector-high bit |
| strap_endian_i | input | 2 | Endian configuration strap |
| priv_i | input | 1 | Access is in a privileged mode |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero unless a privileged read |
| undef_o | output | 1 | Pulse after a refused access |
| strap_err_o | output | 1 | Reserved endian strap seen at reset |
| mmu_en_o | output | 1 | Address translation enable |
| align_chk_o | output | 1 | Strict alignment check enable |
| pred_en_o | output | 1 | Branch prediction enable |
| icache_en_o | output | 1 | Instruction cache enable |
| vec_hi_o | output | 1 | High vectors selected |
| l4_o | output | 1 | Legacy PC-load behaviour |
| unalign_en_o | output | 1 | Unaligned access enable |
| xp_o | output | 1 | Extended page-table format |
| nmfi_o | output | 1 | Fast interrupts non-maskable |
| exc_endian_o | output | 1 | Endian bit for exception entry |
| vec_base_o | output | 32 | Exception vector base address |

## Verification
The hardest case to reach from the ports is the reserved strap code, because its effects span resets. The bench resets with code 01, then moves the strap to a legal value while running. It checks that the flag stays set and the register is unchanged. A later reset with a legal code must clear the flag. Bit positions are checked by writing a walking one through all 32 bits. Each write is preceded by a read in the same cycle, so the old-value rule is exercised at every step.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int REG_W = 32;

  localparam int B_M    = 0;
  localparam int B_A    = 1;
  localparam int B_Z    = 11;
  localparam int B_I    = 12;
  localparam int B_V    = 13;
  localparam int B_ONE  = 14;
  localparam int B_L4   = 15;
  localparam int B_U    = 22;
  localparam int B_XP   = 23;
  localparam int B_EE   = 25;
  localparam int B_NMFI = 27;

  localparam int FIX_LSB = 16;
  localparam int FIX_W   = 6;
  localparam logic [FIX_W-1:0] FIX_VAL = 6'b000101;

  typedef enum logic [1:0] {
    STRAP_LE   = 2'b00,
    STRAP_RSVD = 2'b01,
    STRAP_MIX  = 2'b10,
    STRAP_BE   = 2'b11
  } strap_e;

  typedef struct packed {
    logic mmu;
    logic align;
    logic pred;
    logic icache;
    logic vec_hi;
    logic l4;
    logic unalign;
    logic xp;
    logic exc_ee;
    logic nmfi;
  } ctl_fields_t;

  function automatic logic [REG_W-1:0] wr_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[B_M] = 1'b1; m[B_A] = 1'b1; m[B_Z] = 1'b1; m[B_I] = 1'b1;
    m[B_V] = 1'b1; m[B_L4] = 1'b1; m[B_U] = 1'b1; m[B_XP] = 1'b1;
    m[B_EE] = 1'b1; m[B_NMFI] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] const_bits();
    logic [REG_W-1:0] c;
    c = '0;
    c[B_ONE] = 1'b1;
    c[FIX_LSB +: FIX_W] = FIX_VAL;
    return c;
  endfunction
endpackage

// File: rtl/sctl_reset_gen.sv
module sctl_reset_gen
  import sctl_pkg::*;
(
  input  logic [1:0]       strap_endian_i,
  input  logic             strap_vec_hi_i,
  output logic [REG_W-1:0] rst_val_o,
  output logic             strap_bad_o
);
  strap_e code;
  assign code = strap_e'(strap_endian_i);

  always_comb begin
    rst_val_o      = '0;
    rst_val_o[B_V] = strap_vec_hi_i;
    strap_bad_o    = 1'b0;
    unique case (code)
      STRAP_MIX: rst_val_o[B_U] = 1'b1;
      STRAP_BE: begin
        rst_val_o[B_U]  = 1'b1;
        rst_val_o[B_EE] = 1'b1;
      end
      STRAP_RSVD: strap_bad_o = 1'b1; // treated as little-endian
      default: ;
    endcase
  end
endmodule

// File: rtl/sctl_store.sv
module sctl_store
  import sctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] rst_val_i,
  input  logic             wr_en_i,
  input  logic             priv_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  localparam logic [REG_W-1:0] MASK = wr_mask();

  logic wr_ok;
  assign wr_ok = wr_en_i & priv_i;

  // only writable bits have flops
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (MASK[b]) begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q_o[b] <= rst_val_i[b];
        else if (wr_ok) q_o[b] <= wdata_i[b];
      end
    end else begin : g_tie
      assign q_o[b] = 1'b0;
    end
  end

  assert_no_unpriv_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i) |=> $stable(q_o));

  assert_write_lands_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (q_o == ($past(wdata_i) & MASK)));
endmodule

// File: rtl/sctl_decode.sv
module sctl_decode
  import sctl_pkg::*;
#(
  parameter logic [REG_W-1:0] VEC_HI_BASE = 32'hFFFF_0000,
  parameter logic [REG_W-1:0] VEC_LO_BASE = 32'h0000_0000
) (
  input  logic [REG_W-1:0] q_i,
  output ctl_fields_t      fields_o,
  output logic [REG_W-1:0] view_o,
  output logic [REG_W-1:0] vec_base_o
);
  localparam logic [REG_W-1:0] CONST = const_bits();

  assign view_o = q_i | CONST;

  always_comb begin
    fields_o.mmu     = q_i[B_M];
    fields_o.align   = q_i[B_A];
    fields_o.pred    = q_i[B_Z];
    fields_o.icache  = q_i[B_I];
    fields_o.vec_hi  = q_i[B_V];
    fields_o.l4      = q_i[B_L4];
    fields_o.unalign = q_i[B_U];
    fields_o.xp      = q_i[B_XP];
    fields_o.exc_ee  = q_i[B_EE];
    fields_o.nmfi    = q_i[B_NMFI];
  end

  assign vec_base_o = q_i[B_V] ? VEC_HI_BASE : VEC_LO_BASE;
endmodule

// File: rtl/sys_ctrl_reg.sv
module sys_ctrl_reg
  import sctl_pkg::*;
#(
  parameter logic [31:0] VEC_HI_BASE = 32'hFFFF_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strap_vec_hi_i,
  input  logic [1:0]  strap_endian_i,
  input  logic        priv_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        undef_o,
  output logic        strap_err_o,
  output logic        mmu_en_o,
  output logic        align_chk_o,
  output logic        pred_en_o,
  output logic        icache_en_o,
  output logic        vec_hi_o,
  output logic        l4_o,
  output logic        unalign_en_o,
  output logic        xp_o,
  output logic        nmfi_o,
  output logic        exc_endian_o,
  output logic [31:0] vec_base_o
);
  logic [REG_W-1:0] rst_val, q, view;
  logic             strap_bad;
  ctl_fields_t      f;

  sctl_reset_gen u_rst (
    .strap_endian_i (strap_endian_i),
    .strap_vec_hi_i (strap_vec_hi_i),
    .rst_val_o      (rst_val),
    .strap_bad_o    (strap_bad)
  );

  sctl_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (rst_val),
    .wr_en_i   (wr_en_i),
    .priv_i    (priv_i),
    .wdata_i   (wdata_i),
    .q_o       (q)
  );

  sctl_decode #(.VEC_HI_BASE(VEC_HI_BASE)) u_dec (
    .q_i        (q),
    .fields_o   (f),
    .view_o     (view),
    .vec_base_o (vec_base_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      undef_o     <= 1'b0;
      strap_err_o <= strap_bad;
    end else begin
      undef_o     <= (wr_en_i | rd_en_i) & ~priv_i;
    end
  end

  assign rdata_o      = (rd_en_i && priv_i) ? view : '0;
  assign mmu_en_o     = f.mmu;
  assign align_chk_o  = f.align;
  assign pred_en_o    = f.pred;
  assign icache_en_o  = f.icache;
  assign vec_hi_o     = f.vec_hi;
  assign l4_o         = f.l4;
  assign unalign_en_o = f.unalign;
  assign xp_o         = f.xp;
  assign nmfi_o       = f.nmfi;
  assign exc_endian_o = f.exc_ee;

  assert_undef_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || rd_en_i) && !priv_i) |=> undef_o);

  assert_unpriv_read_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !priv_i |-> (rdata_o == '0));

  assert_fixed_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && priv_i) |-> (rdata_o[21:16] == 6'b000101 && rdata_o[14]));

  assert_zero_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && priv_i) |-> (!rdata_o[24] && !rdata_o[26]));

  assert_vec_base_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_hi_o |-> (vec_base_o == VEC_HI_BASE));

  assert_strap_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_err_o |=> strap_err_o);
endmodule

// File: tb/sim_sys_ctrl_reg.sv
module sim_sys_ctrl_reg;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        strap_vec_hi = 1'b0;
  logic [1:0]  strap_endian = 2'b00;
  logic        priv = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, vec_base;
  logic        undef, serr, mmu, aln, prd, ic, vh, l4, ua, xp, nmfi, exe;

  sys_ctrl_reg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .strap_vec_hi_i(strap_vec_hi),
    .strap_endian_i(strap_endian), .priv_i(priv), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .undef_o(undef), .strap_err_o(serr),
    .mmu_en_o(mmu), .align_chk_o(aln), .pred_en_o(prd), .icache_en_o(ic),
    .vec_hi_o(vh), .l4_o(l4), .unalign_en_o(ua), .xp_o(xp), .nmfi_o(nmfi),
    .exc_endian_o(exe), .vec_base_o(vec_base)
  );

  int total = 0, fails = 0;
  logic [31:0] m;
  logic        m_undef, m_err;

  // R8 writable positions, R6 constants
  function automatic logic [31:0] wmask();
    int pos[10] = '{0, 1, 11, 12, 13, 15, 22, 23, 25, 27};
    logic [31:0] r = '0;
    foreach (pos[i]) r[pos[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (rd && priv) return (m & wmask()) | 32'h0005_4000;
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_all();
    chk("R1 R3 R6 R7 rdata", rdata, exp_rdata());
    chk("R8 fields", {22'd0, mmu, aln, prd, ic, vh, l4, ua, xp, nmfi, exe},
        {22'd0, m[0], m[1], m[11], m[12], m[13], m[15], m[22], m[23], m[27], m[25]});
    chk("R9 vec_base", vec_base, m[13] ? 32'hFFFF_0000 : 32'h0);
    chk("R10 exc_endian", {31'd0, exe}, {31'd0, m[25]});
    chk("R2 undef", {31'd0, undef}, {31'd0, m_undef});
    chk("R5 strap_err", {31'd0, serr}, {31'd0, m_err});
  endtask

  // called at negedge
  task automatic cyc(logic w, logic r, logic p, logic [31:0] d);
    wr = w; rd = r; priv = p; wdata = d;
    #0.5;
    chk("R1 R3 rdata before edge", rdata, exp_rdata());
    @(posedge clk);
    if (w && p) m = d & wmask();
    m_undef = (w || r) && !p;
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset(logic [1:0] st, logic v);
    wr = 0; rd = 0; priv = 0;
    rst_ni = 1'b0;
    strap_endian = st; strap_vec_hi = v;
    @(negedge clk);
    m = '0;
    m[13] = v;
    m[22] = st[1];
    m[25] = (st == 2'b11);
    m_err = (st == 2'b01);
    m_undef = 1'b0;
    rd = 1; priv = 1;
    #0.5;
    check_all(); // R4 R5 during reset
    rst_ni = 1'b1;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(2'b00, 1'b0);                 // R4 R5
    cyc(1, 1, 1, 32'hFFFF_FFFF);           // R1 R6 R7
    cyc(0, 1, 1, 32'h0);
    cyc(0, 1, 0, 32'h0);                   // R3 R2
    cyc(1, 0, 0, 32'h0);                   // R2 ignored
    cyc(0, 1, 1, 32'h0);
    cyc(0, 0, 0, 32'h0);
    cyc(1, 1, 1, 32'h0);
    for (int b = 0; b < 32; b++) begin     // R8 R9 R10 walking one
      cyc(1, 1, 1, 32'h1 << b);
      cyc(0, 1, 1, 32'h0);
    end
    cyc(1, 1, 1, 32'hA5A5_5A5A);
    cyc(1, 1, 1, 32'h5A5A_A5A5);
    cyc(0, 1, 1, 32'h0);
    do_reset(2'b10, 1'b1);                 // R5 R9
    cyc(0, 1, 1, 32'h0);
    do_reset(2'b11, 1'b0);                 // R5 R10
    cyc(0, 1, 1, 32'h0);
    do_reset(2'b01, 1'b1);                 // R5 reserved
    strap_endian = 2'b11; strap_vec_hi = 1'b0;
    cyc(0, 1, 1, 32'h0);
    cyc(1, 1, 1, 32'h0200_2000);
    cyc(0, 1, 1, 32'h0);
    do_reset(2'b00, 1'b1);                 // R5 flag clears
    cyc(0, 1, 1, 32'h0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule